// File: doc/BRIEF.md
# Quarter-Slot Toggle Edge Generator

This block is the digital output stage of an interpolating phase modulator, modelled as an oversampled bitstream. Every sample period the upstream zero-crossing solver delivers four (enable, position) pairs, one for each quarter of the period. The block emits one word of `BITS_PER_SAMPLE` bits per clock. Each bit is one time step of the square-wave carrier, and bit 0 is the earliest step.

An enabled quarter fires a single toggle pulse at its coded step, and only within its own quarter. The pulses of all quarters are merged by an OR. A toggle register then walks the merged pulse train and flips the carrier level at each pulse. The level carries from one word into the next. A quarter that is disabled leaves the level untouched, so the carrier holds its state through that quarter.

Top module: `qtg_edge_gen`

## Requirements
- R1: Each rising clock edge takes one set of quarter inputs and registers one output word. The word appears on `bits_out` one clock after the inputs were presented and does not change between edges. Bit 0 of the word is the earliest time step.
- R2: An enabled quarter q with code c toggles the carrier at step q*(BITS_PER_SAMPLE/4)+c. The step at that position already shows the new level. Quarter q's code occupies `q_pos[q*POS_W +: POS_W]`, and `q_en[q]` enables quarter q.
- R3: Each quarter causes at most one level change, and only within its own slot of BITS_PER_SAMPLE/4 steps. With all four quarters enabled, the word has exactly four changes, one per slot.
- R4: A disabled quarter causes no level change, whatever its code. If all four quarters are disabled, every bit of the word equals the last bit of the previous word.
- R5: The level carries across words: the first step of a word starts from the last bit of the previous word.
- R6: Reset is asynchronous and active low. While reset is asserted, and for two clock edges after it is released, `bits_out` is all zeros. The first word after that starts from the low level.
- R7: Consecutive toggles must be at least floor(2*BITS_PER_SAMPLE/7) steps apart, counting across word boundaries. A toggle pair exactly at that spacing is reproduced correctly. A closer pair is a protocol error and is flagged.
- R8: No toggle is lost in the merge. The number of level changes in a word, counted against the previous word's last bit, equals the number of enabled quarters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock; one output word per edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| q_en | input | 4 | Per-quarter toggle enable, bit q for quarter q |
| q_pos | input | 4*POS_W | Per-quarter toggle step within its slot, quarter q at bits q*POS_W upward |
| bits_out | output | BITS_PER_SAMPLE | Carrier samples for one period, bit 0 earliest |

## Verification
A quarter set driven before a rising edge shows up as a word on `bits_out` after that edge. The bench therefore drives on the falling edge and compares one falling edge later. One check confirms that the output has not yet moved shortly after the inputs change. After reset is released, the word stays zero for two edges while the synchronizer clears, and the third edge produces the first real word. The bench samples each of those edges. The expected words are worked out by hand from the toggle positions and the carried level. The stimulus respects the minimum toggle spacing, and one vector lands exactly on it.

// File: rtl/qtg_pkg.sv
package qtg_pkg;
  // Number of sub-units per sample period; the slot structure depends on it.
  localparam int unsigned QUARTERS = 4;
  // Flops in the reset-release synchronizer.
  localparam int unsigned SYNC_STAGES = 2;

  // Shortest legal spacing between toggles, in output steps (0.29 of a period).
  function automatic int unsigned min_run_bits(input int unsigned steps);
    return (2 * steps) / 7;
  endfunction
endpackage

// File: rtl/qtg_slot_pulse.sv
// One sub-unit: a one-hot pulse at the coded step of its slot, or none.
module qtg_slot_pulse #(
  parameter  int unsigned SLOT_BITS = 4,
  localparam int unsigned POS_W     = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
  input  logic                 en,
  input  logic [POS_W-1:0]     code,
  output logic [SLOT_BITS-1:0] pulse
);
  for (genvar i = 0; i < SLOT_BITS; i++) begin : g_step
    assign pulse[i] = en & (code == POS_W'(i));
  end
endmodule

// File: rtl/qtg_pulse_merge.sv
// Places each slot's pulses at its quarter of the period and ORs them together.
module qtg_pulse_merge import qtg_pkg::*; #(
  parameter  int unsigned SLOT_BITS = 4,
  localparam int unsigned STEPS     = QUARTERS * SLOT_BITS
) (
  input  logic [STEPS-1:0] slot_pulse,
  output logic [STEPS-1:0] tog
);
  logic [STEPS-1:0] placed [QUARTERS];

  for (genvar q = 0; q < QUARTERS; q++) begin : g_place
    assign placed[q] = STEPS'(slot_pulse[q*SLOT_BITS +: SLOT_BITS]) << (q * SLOT_BITS);
  end

  always_comb begin
    tog = '0;
    for (int q = 0; q < QUARTERS; q++) begin
      tog = tog | placed[q];
    end
  end
endmodule

// File: rtl/qtg_toggle_reg.sv
// Toggle register: walks the merged pulse train step by step and carries the level.
module qtg_toggle_reg #(
  parameter int unsigned STEPS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STEPS-1:0] tog,
  output logic [STEPS-1:0] bits_q
);
  logic [STEPS-1:0] bits_d;

  always_comb begin
    logic lvl;
    lvl = bits_q[STEPS-1];
    for (int j = 0; j < STEPS; j++) begin
      lvl       = lvl ^ tog[j];
      bits_d[j] = lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else begin
      bits_q <= bits_d;
    end
  end
endmodule

// File: rtl/qtg_edge_gen.sv
module qtg_edge_gen import qtg_pkg::*; #(
  parameter  int unsigned BITS_PER_SAMPLE = 16,
  localparam int unsigned SLOT_BITS       = BITS_PER_SAMPLE / QUARTERS,
  localparam int unsigned POS_W           = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [QUARTERS-1:0]         q_en,
  input  logic [QUARTERS*POS_W-1:0]   q_pos,
  output logic [BITS_PER_SAMPLE-1:0]  bits_out
);
  // Reset: asserted asynchronously, released after SYNC_STAGES edges.
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic [SYNC_STAGES-1:0] rst_pipe_d;
  logic                   rst_sync_n;

  always_comb begin
    rst_pipe_d = {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  // Per-quarter pulse generation.
  logic [BITS_PER_SAMPLE-1:0] slot_pulse;

  for (genvar q = 0; q < QUARTERS; q++) begin : g_quarter
    qtg_slot_pulse #(.SLOT_BITS(SLOT_BITS)) u_slot (
      .en    (q_en[q]),
      .code  (q_pos[q*POS_W +: POS_W]),
      .pulse (slot_pulse[q*SLOT_BITS +: SLOT_BITS])
    );
  end

  // Merge and toggle.
  logic [BITS_PER_SAMPLE-1:0] tog;

  qtg_pulse_merge #(.SLOT_BITS(SLOT_BITS)) u_merge (
    .slot_pulse (slot_pulse),
    .tog        (tog)
  );

  qtg_toggle_reg #(.STEPS(BITS_PER_SAMPLE)) u_tff (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tog    (tog),
    .bits_q (bits_out)
  );
endmodule

// File: rtl/qtg_edge_gen_checker.sv
module qtg_edge_gen_checker import qtg_pkg::*; #(
  parameter  int unsigned BITS_PER_SAMPLE = 16,
  localparam int unsigned SLOT_BITS       = BITS_PER_SAMPLE / QUARTERS,
  localparam int unsigned MIN_RUN         = min_run_bits(BITS_PER_SAMPLE)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [QUARTERS-1:0]        q_en,
  input logic [BITS_PER_SAMPLE-1:0] bits_out
);
  logic                       last_q;
  logic                       seen_q;
  int unsigned                run_q;
  int unsigned                run_d;
  logic                       short_run;
  logic [BITS_PER_SAMPLE-1:0] trans;

  // Level changes in the current word, measured against the previous word's last bit.
  assign trans = bits_out ^ {bits_out[BITS_PER_SAMPLE-2:0], last_q};

  always_comb begin
    int unsigned r;
    r         = run_q;
    short_run = 1'b0;
    for (int j = 0; j < BITS_PER_SAMPLE; j++) begin
      if (r < BITS_PER_SAMPLE) r = r + 1;
      if (trans[j]) begin
        if (r < MIN_RUN) short_run = 1'b1;
        r = 0;
      end
    end
    run_d = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= BITS_PER_SAMPLE;
    end else begin
      last_q <= bits_out[BITS_PER_SAMPLE-1];
      seen_q <= 1'b1;
      run_q  <= run_d;
    end
  end

  // R6: output stays zero while the synchronized reset is low.
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r6_reset_zero: assert (bits_out == '0)
        else $error("R6 output not zero during reset");
    end
  end

  // R3: one change per enabled quarter, inside its own slot.
  for (genvar q = 0; q < QUARTERS; q++) begin : g_slot_chk
    a_r3_one_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> ($countones(trans[q*SLOT_BITS +: SLOT_BITS]) == int'($past(q_en[q]))))
      else $error("R3 slot %0d change count wrong", q);
  end

  // R8: merge loses no toggle.
  a_r8_no_lost_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ($countones(trans) == $countones($past(q_en))))
    else $error("R8 toggle count mismatch");

  // R4: all quarters disabled holds the level.
  a_r4_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ($past(q_en) == '0)) |-> (bits_out == {BITS_PER_SAMPLE{last_q}}))
    else $error("R4 level not held");

  // R7: toggles closer than the minimum spacing are a protocol error.
  a_r7_min_run: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> !short_run)
    else $error("R7 toggles closer than %0d steps", MIN_RUN);
endmodule

bind qtg_edge_gen qtg_edge_gen_checker #(.BITS_PER_SAMPLE(BITS_PER_SAMPLE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .q_en     (q_en),
  .bits_out (bits_out)
);

// File: tb/qtg_edge_gen_bench.sv
`timescale 1ns/1ps
module qtg_edge_gen_bench;
  localparam int unsigned K     = 16;
  localparam int unsigned POS_W = 2;
  localparam int unsigned NVEC  = 12;

  logic             clk;
  logic             rst_n;
  logic [3:0]       q_en;
  logic [4*POS_W-1:0] q_pos;
  logic [K-1:0]     bits_out;

  int checks;
  int failures;
  bit done;

  qtg_edge_gen #(.BITS_PER_SAMPLE(K)) u_qtg_edge_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_en     (q_en),
    .q_pos    (q_pos),
    .bits_out (bits_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {enables, codes {q3,q2,q1,q0}, expected word}; the level is carried from row to row.
  localparam logic [27:0] VEC [NVEC] = '{
    {4'b0000, 8'h00, 16'h0000},  // idle after reset
    {4'b0001, 8'h01, 16'hFFFE},  // q0 at step 1
    {4'b1111, 8'hAA, 16'hC3C3},  // all quarters, step 2 of each
    {4'b0101, 8'h87, 16'hFF07},  // q0@3, q2@8; disabled codes nonzero
    {4'b1010, 8'hD2, 16'h800F},  // q1@4, q3@15 (last step)
    {4'b0000, 8'hFF, 16'hFFFF},  // all disabled, codes max
    {4'b1000, 8'h3F, 16'h0FFF},  // q3@12 only
    {4'b1111, 8'h00, 16'h0F0F},  // exact minimum spacing across boundary
    {4'b0011, 8'h0F, 16'h0078},  // q0@3, q1@7
    {4'b1100, 8'h50, 16'h1E00},  // q2@9, q3@13
    {4'b0010, 8'h08, 16'hFFC0},  // q1@6
    {4'b0100, 8'h30, 16'h07FF}   // q2@11
  };

  function automatic string vec_tag(input int i);
    case (i)
      1:       return "R2 single toggle";
      2:       return "R3 all four slots";
      3:       return "R4 disabled codes ignored";
      4:       return "R8 toggle at slot edge";
      5:       return "R4 all disabled holds";
      6:       return "R5 level carried";
      7:       return "R7 minimum spacing";
      default: return "R2 toggle position";
    endcase
  endfunction

  task automatic check(input string tag, input logic [K-1:0] act, input logic [K-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Reset release with inputs active during the synchronizer window.
  task automatic release_reset();
    rst_n = 1'b1;
    q_en  = 4'b1111;
    q_pos = '0;
    @(negedge clk);
    check("R6 sync window edge 1", bits_out, '0);
    @(negedge clk);
    check("R6 sync window edge 2", bits_out, '0);
    q_en = 4'b0000;
    @(negedge clk);
    check("R6 first word low", bits_out, '0);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b1;
    q_en     = '0;
    q_pos    = '0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R6 in reset", bits_out, '0);
    repeat (2) @(negedge clk);
    release_reset();

    for (int i = 0; i < NVEC; i++) begin
      q_en  = VEC[i][27:24];
      q_pos = VEC[i][23:16];
      @(negedge clk);
      check(vec_tag(i), bits_out, VEC[i][15:0]);
    end

    // Toggle at step 0 lifts the level high before a mid-run reset.
    q_en  = 4'b0001;
    q_pos = 8'h00;
    @(negedge clk);
    check("R2 toggle at step 0", bits_out, 16'hFFFF);

    q_en = 4'b0000;
    #1 rst_n = 1'b0;
    #0.5;
    check("R6 asynchronous clear", bits_out, '0);
    @(negedge clk);
    release_reset();

    q_en  = 4'b0010;
    q_pos = 8'h00;
    @(negedge clk);
    check("R2 q1 step 4 after reset", bits_out, 16'hFFF0);

    q_en  = 4'b1000;
    q_pos = 8'h00;
    #1;
    check("R1 output waits for edge", bits_out, 16'hFFF0);
    @(negedge clk);
    check("R1 registered word", bits_out, 16'h0FFF);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule